// File: doc/BRIEF.md
# External-Trigger One-Shot Pulse Timer

This block measures time from an edge on an external pin. While it is enabled and idle, it holds a 16-bit up-counter at zero and waits for the chosen pin edge. When that edge arrives, the counter advances once per tick of a prescaled copy of the system clock. When the count equals a compare value, the counter returns to zero, the block halts, and a one-cycle interrupt pulse is raised. The next trigger edge starts a new run from zero.

A mode input controls what the opposite pin edge does during a run. In watchdog mode, it stops the run with no interrupt, so an interrupt means the pin stayed in its active level for longer than the programmed time. In delay mode, the opposite edge is ignored, and so is any further trigger edge, until the match. A pin noise filter sits ahead of the edge detector. It passes a level change only after the change has been steady for eight system clocks. A low-power input bypasses the filter, so that only the two-flop synchronizer remains.

Top module: `ext_trig_timer`

## Requirements
- R1: After reset, and whenever no run is in progress, the counter stays at zero. A run starts only on the selected pin edge: `trig_fall_i`=0 selects the rising edge and `trig_fall_i`=1 selects the falling edge.
- R2: The tick divisor D is set by `psc_sel_i`: 0 gives 1, 1 gives 8, 2 gives 128, 3 gives 2048. With compare value C and the filter on, `irq_o` is high in clock number 11 + (C+1)·D, counting the first clock edge after the pin change as number 1.
- R3: On a match, the counter clears and halts. `irq_o` is high for exactly one cycle.
- R4: With `abort_mode_i`=1, an opposite edge that reaches the counter before the match ends the run. No interrupt is raised.
- R5: With `abort_mode_i`=0, an opposite edge during a run has no effect. A repeated trigger edge during a run is also ignored, and the timing stays anchored to the first edge.
- R6: After any halt (match, abort or disable), the next trigger edge restarts the count from zero with the timing of R2.
- R7: With the filter on, a pin pulse of 4 or fewer system clocks causes no edge. A level held for 8 or more clocks is accepted.
- R8: With `lp_bypass_i`=1, the filter is bypassed. A one-clock pin pulse is accepted, and the latency term in R2 becomes 4 instead of 11.
- R9: While `run_en_i` is low, the counter is forced to zero and halted. Edges that arrive in that time are dropped. After `run_en_i` rises, a fresh trigger edge is needed.
- R10: A compare value of zero matches on the first tick after the trigger.
- R11: During and straight after reset, `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Raw external trigger pin |
| lp_bypass_i | input | 1 | 1 bypasses the noise filter (low-power operation) |
| run_en_i | input | 1 | Run enable; 0 forces idle and drops edges |
| trig_fall_i | input | 1 | Trigger edge select: 0 rising, 1 falling |
| abort_mode_i | input | 1 | 1 makes the opposite edge abort silently |
| psc_sel_i | input | 2 | Tick divisor select |
| cmp_i | input | 16 | Compare value |
| irq_o | output | 1 | One-cycle interrupt request on match |

## Verification
The stimulus table covers both trigger polarities, three divisor settings, a zero compare value and the filter bypass. Each of these is measured as an exact cycle count from pin change to interrupt, so an off-by-one in the filter, the prescaler or the compare shows up as a wrong count. Pin waveforms with a drop and a re-rise during the run separate watchdog mode from delay mode: the same waveform must abort and then restart in one mode, and keep the original timing in the other. Short glitches with the filter on and off tell rejection apart from acceptance. Directed sequences check that disabling mid-run, and edges that arrive while disabled, leave nothing pending.

// File: rtl/ett_pkg.sv
package ett_pkg;

  // Divisor exponent grows by this step per select code above zero
  localparam int unsigned PSC_STEP = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ett_state_e;

  // Power-of-two exponent of the tick divisor for a select code
  function automatic int unsigned psc_shift(input int unsigned sel);
    if (sel == 0) return 0;
    return PSC_STEP * sel - 1;
  endfunction

  // Largest exponent reachable with a select field of the given width
  function automatic int unsigned psc_max_shift(input int unsigned sel_w);
    return psc_shift((1 << sel_w) - 1);
  endfunction

endpackage

// File: rtl/ett_pin_filter.sv
module ett_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic bypass_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          stab_q;
  logic                   lvl_q;
  logic                   rise_q;
  logic                   fall_q;
  logic                   synced;
  logic                   differs;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= pin_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  assign synced  = sync_q[SYNC_STAGES-1];
  assign differs = synced != lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stab_q <= '0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (bypass_i) begin
        stab_q <= '0;
        if (differs) begin
          lvl_q  <= synced;
          rise_q <= synced;
          fall_q <= !synced;
        end
      end else if (differs) begin
        if (stab_q == LAST) begin
          stab_q <= '0;
          lvl_q  <= synced;
          rise_q <= synced;
          fall_q <= !synced;
        end else begin
          stab_q <= stab_q + 1'b1;
        end
      end else begin
        stab_q <= '0;
      end
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
endmodule

// File: rtl/ett_tick_gen.sv
module ett_tick_gen
  import ett_pkg::*;
#(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned PSC_W = psc_max_shift(SEL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] mask;
  int unsigned      shift;

  always_comb begin
    shift = psc_shift(int'(sel_i));
    for (int b = 0; b < PSC_W; b++) mask[b] = (b < shift);
  end

  assign tick_o = active_i && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_q <= '0;
    else if (!active_i) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ett_count_core.sv
module ett_count_core
  import ett_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en_i,
  input  logic             trig_fall_i,
  input  logic             abort_mode_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             running_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             trig_evt_o,
  output logic             opp_evt_o,
  output logic             match_o
);
  ett_state_e       state_q;
  logic [CNT_W-1:0] count_q;
  logic             irq_q;

  function automatic logic hits(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] ref_v);
    return c == ref_v;
  endfunction

  assign trig_evt_o = run_en_i && (trig_fall_i ? fall_i : rise_i);
  assign opp_evt_o  = run_en_i && (trig_fall_i ? rise_i : fall_i);
  assign running_o  = state_q == ST_RUN;
  assign match_o    = hits(count_q, cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (!run_en_i) begin
        state_q <= ST_IDLE;
        count_q <= '0;
      end else if (state_q == ST_IDLE) begin
        count_q <= '0;
        if (trig_evt_o) state_q <= ST_RUN;
      end else if (tick_i && match_o) begin
        state_q <= ST_IDLE;
        count_q <= '0;
        irq_q   <= 1'b1;
      end else if (abort_mode_i && opp_evt_o) begin
        state_q <= ST_IDLE;
        count_q <= '0;
      end else if (tick_i) begin
        count_q <= count_q + 1'b1;
      end
    end
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/ext_trig_timer.sv
module ext_trig_timer
  import ett_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned FILT_LEN    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             lp_bypass_i,
  input  logic             run_en_i,
  input  logic             trig_fall_i,
  input  logic             abort_mode_i,
  input  logic [SEL_W-1:0] psc_sel_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             irq_o
);
  localparam int unsigned PSC_W = psc_max_shift(SEL_W);

  logic             pin_level;
  logic             pin_rise;
  logic             pin_fall;
  logic             tick;
  logic             running;
  logic [CNT_W-1:0] count;
  logic             trig_evt;
  logic             opp_evt;
  logic             match;

  ett_pin_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (pin_i),
    .bypass_i(lp_bypass_i),
    .level_o (pin_level),
    .rise_o  (pin_rise),
    .fall_o  (pin_fall)
  );

  ett_tick_gen #(
    .SEL_W(SEL_W),
    .PSC_W(PSC_W)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .active_i(running),
    .sel_i   (psc_sel_i),
    .tick_o  (tick)
  );

  ett_count_core #(
    .CNT_W(CNT_W)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en_i    (run_en_i),
    .trig_fall_i (trig_fall_i),
    .abort_mode_i(abort_mode_i),
    .rise_i      (pin_rise),
    .fall_i      (pin_fall),
    .tick_i      (tick),
    .cmp_i       (cmp_i),
    .running_o   (running),
    .count_o     (count),
    .irq_o       (irq_o),
    .trig_evt_o  (trig_evt),
    .opp_evt_o   (opp_evt),
    .match_o     (match)
  );
endmodule

// File: rtl/ett_checker.sv
module ett_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en_i,
  input logic             abort_mode_i,
  input logic             irq_o,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic             tick,
  input logic             match,
  input logic             trig_evt,
  input logic             opp_evt
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (count == '0)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en_i && running && tick && !match && !(abort_mode_i && opp_evt))
    |=> (count == $past(count) + CNT_W'(1))); // R2

  AST_HALT_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en_i && running && tick && match) |=> (!running && irq_o)); // R3

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R3

  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en_i && running && abort_mode_i && opp_evt && !(tick && match))
    |=> (!running && !irq_o)); // R4

  AST_RETRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en_i && running && !abort_mode_i && trig_evt && !tick)
    |=> (running && $stable(count))); // R5

  AST_RUN_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en_i |=> (!running && !irq_o)); // R9
endmodule

bind ext_trig_timer ett_checker #(.CNT_W(CNT_W)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_en_i    (run_en_i),
  .abort_mode_i(abort_mode_i),
  .irq_o       (irq_o),
  .running     (running),
  .count       (count),
  .tick        (tick),
  .match       (match),
  .trig_evt    (trig_evt),
  .opp_evt     (opp_evt)
);

// File: tb/ext_trig_timer_bench.sv
`timescale 1ns/1ps
module ext_trig_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic        bypass = 1'b0;
  logic        run_en = 1'b0;
  logic        trig_fall = 1'b0;
  logic        abort_mode = 1'b0;
  logic [1:0]  psc_sel = 2'd0;
  logic [15:0] cmp = 16'd0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ext_trig_timer u_ext_trig_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin),
    .lp_bypass_i (bypass),
    .run_en_i    (run_en),
    .trig_fall_i (trig_fall),
    .abort_mode_i(abort_mode),
    .psc_sel_i   (psc_sel),
    .cmp_i       (cmp),
    .irq_o       (irq)
  );

  typedef struct packed {
    logic        fall;
    logic        mode;
    logic        byp;
    logic [1:0]  sel;
    logic [15:0] cval;
    logic [15:0] t_off;
    logic [15:0] t_on;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 2'd0, 16'd20,  16'd0,  16'd0,  8'd2},  // R2 rising
    '{1'b1, 1'b0, 1'b0, 2'd0, 16'd5,   16'd0,  16'd0,  8'd1},  // R1 falling
    '{1'b0, 1'b0, 1'b0, 2'd1, 16'd3,   16'd0,  16'd0,  8'd2},  // R2 div 8
    '{1'b0, 1'b0, 1'b0, 2'd2, 16'd2,   16'd0,  16'd0,  8'd2},  // R2 div 128
    '{1'b0, 1'b1, 1'b0, 2'd0, 16'd100, 16'd30, 16'd0,  8'd4},  // R4 abort
    '{1'b0, 1'b1, 1'b0, 2'd0, 16'd100, 16'd30, 16'd60, 8'd6},  // R6 restart after abort
    '{1'b0, 1'b0, 1'b0, 2'd0, 16'd100, 16'd30, 16'd60, 8'd5},  // R5 ignored
    '{1'b0, 1'b0, 1'b0, 2'd0, 16'd0,   16'd0,  16'd0,  8'd10}, // R10 zero compare
    '{1'b0, 1'b0, 1'b0, 2'd0, 16'd10,  16'd4,  16'd0,  8'd7},  // R7 glitch
    '{1'b0, 1'b0, 1'b1, 2'd0, 16'd10,  16'd0,  16'd0,  8'd8},  // R8 bypass
    '{1'b1, 1'b1, 1'b0, 2'd0, 16'd50,  16'd20, 16'd0,  8'd4},  // R4 falling abort
    '{1'b0, 1'b0, 1'b1, 2'd0, 16'd10,  16'd1,  16'd0,  8'd8},  // R8 one-clock pulse
    '{1'b0, 1'b1, 1'b0, 2'd0, 16'd10,  16'd40, 16'd0,  8'd3}   // R3 late drop
  };

  function automatic int div_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 8;
      2'd2: return 128;
      default: return 2048;
    endcase
  endfunction

  function automatic int expect_n(input vec_t v);
    int lat = v.byp ? 4 : 11;
    int base = lat + (int'(v.cval) + 1) * div_of(v.sel);
    bit seen = v.byp || (v.t_off == 0) || (v.t_off >= 8);
    if (!seen) return 0;
    if (v.mode && v.t_off != 0 && (int'(v.t_off) + lat < base))
      return (v.t_on != 0) ? int'(v.t_on) + base : 0;
    return base;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm(input bit f, input bit m, input bit b, input logic [1:0] s, input logic [15:0] c);
    @(negedge clk);
    run_en = 1'b0;
    pin = f;
    trig_fall = f; abort_mode = m; bypass = b; psc_sel = s; cmp = c;
    repeat (14) @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
  endtask

  // Drives the active level at offset 0, returns the offset where irq is seen
  task automatic measure(input bit idle, input int t_off, input int t_on,
                         input int limit, output int n);
    n = 0;
    pin = !idle;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (irq) begin n = i; break; end
      if (t_off != 0 && i == t_off) pin = idle;
      if (t_on != 0 && i == t_on) pin = !idle;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    int e;
    // R11 reset state
    repeat (3) @(negedge clk);
    check(irq == 1'b0, "R11", int'(irq), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(irq == 1'b0, "R11", int'(irq), 0);
    end

    // Table of vectors
    for (int v = 0; v < NV; v++) begin
      arm(VECS[v].fall, VECS[v].mode, VECS[v].byp, VECS[v].sel, VECS[v].cval);
      e = expect_n(VECS[v]);
      measure(VECS[v].fall, int'(VECS[v].t_off), int'(VECS[v].t_on), 600, n);
      check(n == e, $sformatf("R%0d vec%0d", VECS[v].req, v), n, e);
      if (n != 0) begin
        @(negedge clk);
        check(irq == 1'b0, "R3 pulse width", int'(irq), 0);
      end
    end

    // R9: disable mid-run, re-enable with pin held active: nothing pending
    arm(1'b0, 1'b0, 1'b0, 2'd0, 16'd50);
    pin = 1'b1;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (i == 20) run_en = 1'b0;
      if (i == 25) run_en = 1'b1;
    end
    measure(1'b0, 0, 0, 300, n);
    check(n == 0, "R9 disable drops run", n, 0);
    // R6: new edge after disable restarts from zero
    pin = 1'b0;
    repeat (15) @(negedge clk);
    measure(1'b0, 0, 0, 600, n);
    check(n == 62, "R6 restart after disable", n, 62);

    // R9: edge arriving while disabled is dropped
    @(negedge clk);
    run_en = 1'b0;
    pin = 1'b0;
    repeat (15) @(negedge clk);
    pin = 1'b1;
    repeat (20) @(negedge clk);
    run_en = 1'b1;
    measure(1'b0, 0, 0, 200, n);
    check(n == 0, "R9 edge while disabled", n, 0);

    // R6: back-to-back runs after a match
    arm(1'b0, 1'b0, 1'b0, 2'd0, 16'd5);
    measure(1'b0, 0, 0, 200, n);
    check(n == 17, "R6 first run", n, 17);
    pin = 1'b0;
    repeat (15) @(negedge clk);
    measure(1'b0, 0, 0, 200, n);
    check(n == 17, "R6 second run", n, 17);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule